// File: doc/BRIEF.md
# Serial Multiply-Accumulate FIR Filter

This block is a direct-form FIR filter with `TAPS` coefficients that spends one multiplier and one accumulator on all of them. Every accepted input sample goes into a small circular history store that always holds the `TAPS` newest samples. The coefficients sit in a bank of their own. After a sample is accepted, the engine walks the taps one per clock cycle. In each cycle it reads one history word and one coefficient, multiplies them and folds the product into a 40-bit running sum. After the last tap it rounds and saturates the sum and presents it as one output word.

Samples and coefficients are signed fixed point. Coefficients are Q1.15, so the sum of products is scaled back by 15 bits. The input side is a valid/ready pair. Ready drops while a result is being computed, so at most one sample is ever in flight. Results come out as a one-cycle valid pulse. A sample offered in the same cycle as a result is taken at once, so in steady state there is one result every `TAPS + 1` cycles.

Top module: `fir_mac_engine`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0, `out_data` is 0, and the history and all coefficients are zero, so the first result after reset is c0·x(n) alone.
- R2: A sample is accepted on a rising clock edge where `in_valid` and `in_ready` are both 1. In the next cycle `in_ready` is 0.
- R3: Each result equals the sum over i = 0..TAPS-1 of c_i·x(n−i), then rounded and saturated as in R8 and R9. Here x(n) is the sample just accepted, x(n−1) is the one before it, and c_i is the coefficient written at `coef_addr` = i.
- R4: `out_valid` rises exactly `TAPS` cycles after the accepting edge and stays high for one cycle only.
- R5: `in_ready` is 0 from the cycle after acceptance until the result cycle. It is 1 in the cycle where `out_valid` is 1.
- R6: While `in_ready` is 0, `in_valid` and `in_data` are ignored, and the offered word never enters the history.
- R7: A coefficient write (`coef_we` = 1 on a clock edge) sets c_i to `coef_wdata` for i = `coef_addr` when `in_ready` is 1. The write is dropped while a computation is running.
- R8: Rounding adds 2^14 to the full-precision sum and then shifts it arithmetically right by 15 bits.
- R9: A rounded value above 32767 gives 32767, and one below −32768 gives −32768.
- R10: `out_data` changes only in a cycle where `out_valid` is 1, and holds its last result in between.
- R11: A sample offered in a result cycle is accepted on that edge, so back-to-back results are spaced `TAPS + 1` cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample offered |
| in_data | input | DATA_W | Signed input sample |
| in_ready | output | 1 | Engine idle, sample can be taken |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | IDX_W | Coefficient index i |
| coef_wdata | input | COEF_W | Signed Q1.15 coefficient value |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | DATA_W | Rounded, saturated filter output |

## Verification
The bench builds the engine with four taps and the default 16-bit sample and coefficient widths and a 40-bit sum. With four taps the history pointer wraps every four samples, so long back-to-back sweeps cross the wrap point many times. Each tap position is checked on its own with impulse-like coefficient sets. The small tap count also lets the bench drive the sum past both saturation limits and place exact half-LSB values on the rounding boundary, with every expected result computed in wide integer arithmetic.

// File: rtl/fir_pkg.sv
package fir_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

endpackage

// File: rtl/fir_sample_ring.sv
module fir_sample_ring #(
    parameter int DATA_W = 16,
    parameter int TAPS   = 8,
    localparam int IDX_W = $clog2(TAPS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic signed [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]         rd_idx,
    output logic signed [DATA_W-1:0] rd_data
);

    logic signed [DATA_W-1:0] mem_d [TAPS];
    logic signed [DATA_W-1:0] mem_q [TAPS];

    always_comb begin
        for (int i = 0; i < TAPS; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (wr_en) begin
            mem_d[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < TAPS; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < TAPS; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rd_data = mem_q[rd_idx];

endmodule

// File: rtl/fir_coef_bank.sv
module fir_coef_bank #(
    parameter int COEF_W = 16,
    parameter int TAPS   = 8,
    localparam int IDX_W = $clog2(TAPS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic signed [COEF_W-1:0] wr_data,
    input  logic [IDX_W-1:0]         rd_idx,
    output logic signed [COEF_W-1:0] rd_data
);

    logic signed [COEF_W-1:0] bank_d [TAPS];
    logic signed [COEF_W-1:0] bank_q [TAPS];

    always_comb begin
        for (int i = 0; i < TAPS; i++) begin
            bank_d[i] = bank_q[i];
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                bank_d[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < TAPS; i++) begin
                bank_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < TAPS; i++) begin
                bank_q[i] <= bank_d[i];
            end
        end
    end

    assign rd_data = bank_q[rd_idx];

endmodule

// File: rtl/fir_mac_unit.sv
module fir_mac_unit #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int ACC_W  = 40,
    parameter int FRAC   = 15,
    localparam int PROD_W = DATA_W + COEF_W
) (
    input  logic signed [DATA_W-1:0] x_in,
    input  logic signed [COEF_W-1:0] c_in,
    input  logic signed [ACC_W-1:0]  acc_in,
    input  logic                     first,
    output logic signed [ACC_W-1:0]  acc_out,
    output logic signed [DATA_W-1:0] y_out
);

    localparam logic signed [ACC_W-1:0] Y_MAX =
        {{(ACC_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] Y_MIN =
        {{(ACC_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};
    localparam logic signed [ACC_W-1:0] HALF =
        ACC_W'(1) <<< (FRAC - 1);

    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  prod_ext;
    logic signed [ACC_W-1:0]  rounded;
    logic signed [ACC_W-1:0]  scaled;

    always_comb begin
        prod     = x_in * c_in;
        prod_ext = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
        acc_out  = first ? prod_ext : (acc_in + prod_ext);
        rounded  = acc_out + HALF;
        scaled   = rounded >>> FRAC;
        if (scaled > Y_MAX) begin
            y_out = Y_MAX[DATA_W-1:0];
        end else if (scaled < Y_MIN) begin
            y_out = Y_MIN[DATA_W-1:0];
        end else begin
            y_out = scaled[DATA_W-1:0];
        end
    end

endmodule

// File: rtl/fir_mac_engine.sv
module fir_mac_engine #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int ACC_W  = 40,
    parameter int TAPS   = 8,
    localparam int IDX_W = $clog2(TAPS),
    localparam int FRAC  = COEF_W - 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_data,
    output logic                     in_ready,
    input  logic                     coef_we,
    input  logic [IDX_W-1:0]         coef_addr,
    input  logic signed [COEF_W-1:0] coef_wdata,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_data
);

    import fir_pkg::*;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TAPS - 1);

    typedef struct packed {
        phase_e                   ph;
        logic [IDX_W-1:0]         tap;
        logic [IDX_W-1:0]         rd;
        logic [IDX_W-1:0]         wr;
        logic signed [ACC_W-1:0]  acc;
        logic signed [DATA_W-1:0] y;
        logic                     y_vld;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                     take_smp;
    logic                     coef_wr_ok;
    logic signed [DATA_W-1:0] x_rd;
    logic signed [COEF_W-1:0] c_rd;
    logic signed [ACC_W-1:0]  acc_nxt;
    logic signed [DATA_W-1:0] y_nxt;

    function automatic logic [IDX_W-1:0] ptr_inc(input logic [IDX_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [IDX_W-1:0] ptr_dec(input logic [IDX_W-1:0] p);
        return (p == '0) ? LAST_IDX : p - 1'b1;
    endfunction

    assign take_smp   = in_valid && (ctl_q.ph == PH_IDLE);
    assign coef_wr_ok = coef_we && (ctl_q.ph == PH_IDLE);

    fir_sample_ring #(
        .DATA_W (DATA_W),
        .TAPS   (TAPS)
    ) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (take_smp),
        .wr_idx  (ctl_q.wr),
        .wr_data (in_data),
        .rd_idx  (ctl_q.rd),
        .rd_data (x_rd)
    );

    fir_coef_bank #(
        .COEF_W (COEF_W),
        .TAPS   (TAPS)
    ) u_coef (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (coef_wr_ok),
        .wr_idx  (coef_addr),
        .wr_data (coef_wdata),
        .rd_idx  (ctl_q.tap),
        .rd_data (c_rd)
    );

    fir_mac_unit #(
        .DATA_W (DATA_W),
        .COEF_W (COEF_W),
        .ACC_W  (ACC_W),
        .FRAC   (FRAC)
    ) u_mac (
        .x_in    (x_rd),
        .c_in    (c_rd),
        .acc_in  (ctl_q.acc),
        .first   (ctl_q.tap == '0),
        .acc_out (acc_nxt),
        .y_out   (y_nxt)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.y_vld = 1'b0;
        unique case (ctl_q.ph)
            PH_IDLE: begin
                if (take_smp) begin
                    ctl_d.ph  = PH_RUN;
                    ctl_d.tap = '0;
                    ctl_d.rd  = ctl_q.wr;
                    ctl_d.wr  = ptr_inc(ctl_q.wr);
                end
            end
            PH_RUN: begin
                ctl_d.acc = acc_nxt;
                ctl_d.rd  = ptr_dec(ctl_q.rd);
                if (ctl_q.tap == LAST_IDX) begin
                    ctl_d.ph    = PH_IDLE;
                    ctl_d.y     = y_nxt;
                    ctl_d.y_vld = 1'b1;
                end else begin
                    ctl_d.tap = ctl_q.tap + 1'b1;
                end
            end
            default: ctl_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{ph: PH_IDLE, tap: '0, rd: '0, wr: '0,
                       acc: '0, y: '0, y_vld: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign in_ready  = (ctl_q.ph == PH_IDLE);
    assign out_valid = ctl_q.y_vld;
    assign out_data  = ctl_q.y;

endmodule

// File: rtl/fir_mac_engine_chk.sv
module fir_mac_engine_chk #(
    parameter int DATA_W = 16,
    parameter int TAPS   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data
);

    logic        pend_q;
    logic [15:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            cnt_q  <= '0;
        end else if (in_valid && in_ready) begin
            pend_q <= 1'b1;
            cnt_q  <= '0;
        end else if (out_valid) begin
            pend_q <= 1'b0;
        end else if (pend_q) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (pend_q && (cnt_q == 16'(TAPS))));

    p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    p_ready_at_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> in_ready);

    p_busy_not_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !out_valid) |-> !in_ready);

    p_hold_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_data) |-> out_valid);

endmodule

bind fir_mac_engine fir_mac_engine_chk #(
    .DATA_W (DATA_W),
    .TAPS   (TAPS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/fir_mac_engine_tb.sv
module fir_mac_engine_tb;

    localparam int TB_TAPS = 4;
    localparam int IW      = $clog2(TB_TAPS);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_data = '0;
    logic               in_ready;
    logic               coef_we = 1'b0;
    logic [IW-1:0]      coef_addr = '0;
    logic signed [15:0] coef_wdata = '0;
    logic               out_valid;
    logic signed [15:0] out_data;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int last_out = -1;
    int seed = 32'h1234_5678;
    logic signed [15:0] last_y = '0;
    logic signed [15:0] hist [TB_TAPS];
    logic signed [15:0] cf   [TB_TAPS];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fir_mac_engine #(
        .DATA_W (16),
        .COEF_W (16),
        .ACC_W  (40),
        .TAPS   (TB_TAPS)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_ready   (in_ready),
        .coef_we    (coef_we),
        .coef_addr  (coef_addr),
        .coef_wdata (coef_wdata),
        .out_valid  (out_valid),
        .out_data   (out_data)
    );

    task automatic check_eq(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic signed [15:0] model_y();
        longint acc = 0;
        for (int i = 0; i < TB_TAPS; i++) begin
            acc += longint'(hist[i]) * longint'(cf[i]);
        end
        acc = (acc + 16384) >>> 15;
        if (acc > 32767) acc = 32767;
        if (acc < -32768) acc = -32768;
        return 16'(acc);
    endfunction

    function automatic logic signed [15:0] next_rand();
        seed = seed * 1103515245 + 12345;
        return seed[30:15];
    endfunction

    task automatic write_coef(input int idx, input logic signed [15:0] v);
        coef_we    = 1'b1;
        coef_addr  = IW'(idx);
        coef_wdata = v;
        @(negedge clk);
        coef_we    = 1'b0;
        cf[idx]    = v;
    endtask

    // mode 0: plain; 1: keep offering junk while busy; 2: coefficient write while busy
    task automatic push(input logic signed [15:0] s, input int mode, input string tag);
        int lat;
        bit busy_ok;
        logic signed [15:0] exp_y;
        int acc_cyc;
        in_data  = s;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        acc_cyc = cyc;
        for (int i = TB_TAPS - 1; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = s;
        exp_y = model_y();
        @(negedge clk);
        check_eq("R4 single-cycle pulse", longint'(out_valid), 0);
        if (mode == 1) begin
            in_data = ~s;
        end else begin
            in_valid = 1'b0;
        end
        if (mode == 2) begin
            coef_we    = 1'b1;
            coef_addr  = '0;
            coef_wdata = 16'sd12345;
        end
        lat = 0;
        busy_ok = 1'b1;
        while (!out_valid && lat < TB_TAPS + 4) begin
            if (in_ready) busy_ok = 1'b0;
            @(negedge clk);
            lat++;
            if (lat == 1) coef_we = 1'b0;
            if (lat == TB_TAPS - 1) in_valid = 1'b0;
        end
        check_eq("R5 ready low while busy", longint'(busy_ok), 1);
        check_eq("R4 latency", lat, TB_TAPS);
        check_eq(tag, longint'(out_data), longint'(exp_y));
        check_eq("R5 ready in result cycle", longint'(in_ready), 1);
        if (last_out >= 0) begin
            check_eq("R11 result spacing", cyc - last_out, TB_TAPS + 1);
        end
        last_out = cyc;
        last_y = out_data;
        if (acc_cyc < 0) $display("unreachable");
    endtask

    task automatic load_set(input int kind);
        last_out = -1;
        for (int i = 0; i < TB_TAPS; i++) begin
            logic signed [15:0] v;
            case (kind)
                0: v = next_rand();
                1: v = (i == 0) ? 16'sd16384 : 16'sd0;
                2: v = 16'sd32767;
                3: v = 16'(i * 9000 - 13000);
                default: v = (i == kind - 4) ? 16'sd32767 : 16'sd0;
            endcase
            write_coef(i, v);
        end
        check_eq("R10 output held across idle", longint'(out_data), longint'(last_y));
    endtask

    initial begin
        for (int i = 0; i < TB_TAPS; i++) begin
            hist[i] = '0;
            cf[i]   = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1 ready after reset", longint'(in_ready), 1);
        check_eq("R1 valid after reset", longint'(out_valid), 0);
        check_eq("R1 data after reset", longint'(out_data), 0);

        // R7: coefficients written while idle are used; first result has zero history (R1)
        load_set(3);
        push(16'sd1000, 0, "R1 first result from zero history");
        push(-16'sd2000, 0, "R7 written coefficients used");

        // each tap alone (R3)
        for (int k = 0; k < TB_TAPS; k++) begin
            load_set(4 + k);
            for (int j = 0; j < 2 * TB_TAPS; j++) push(next_rand(), 0, "R3 single-tap position");
        end

        // random sweeps with pointer wrap, back-to-back (R3, R11)
        for (int set = 0; set < 4; set++) begin
            load_set(0);
            for (int j = 0; j < 40; j++) push(next_rand(), 0, "R3 random sweep");
        end

        // rounding boundary, c0 = 0.5 (R8)
        load_set(1);
        push(16'sd1, 0, "R8 +half rounds up");
        push(-16'sd1, 0, "R8 -half rounds toward +inf");
        push(16'sd3, 0, "R8 1.5 rounds to 2");
        push(-16'sd3, 0, "R8 -1.5 rounds to -1");

        // saturation (R9)
        load_set(2);
        for (int j = 0; j < TB_TAPS; j++) push(16'sd32767, 0, "R9 positive saturation");
        check_eq("R9 positive limit", longint'(out_data), 32767);
        for (int j = 0; j < TB_TAPS; j++) push(-16'sd32768, 0, "R9 negative saturation");
        check_eq("R9 negative limit", longint'(out_data), -32768);

        // ignored input while busy (R6) and ignored coefficient write while busy (R7)
        load_set(0);
        for (int j = 0; j < TB_TAPS; j++) push(next_rand(), 0, "R3 refill");
        push(16'sd777, 1, "R3 before ignored offers");
        push(16'sd555, 0, "R6 busy offers not in history");
        push(-16'sd321, 2, "R7 busy coefficient write dropped");
        push(16'sd4321, 0, "R7 coefficients unchanged after busy write");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule